// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine with Abort Recovery

This block is the transmit half of a packet DMA engine. It walks a ring of buffer descriptors held in an internal register array. Each entry carries an ownership bit, start-of-packet and end-of-packet flags, a buffer pointer and a length. For every owned descriptor, the engine reads the buffer through a byte-read port and streams the bytes to a serial framer over a valid/ready interface. When it finishes a descriptor it hands that descriptor back to software by clearing its ownership bit. It then moves to the next ring entry, wrapping from the last entry to entry 0.

If clear-to-send drops while a packet is going out, the engine aborts and raises an aborted status flag. It then halts until software asserts the start and poll controls in the same cycle. A restart never continues in the middle of a packet. If the current descriptor opens a packet, that packet is sent again from its first byte. Otherwise the engine releases descriptors one per cycle until it reaches the next packet start, where it begins sending, or a descriptor it does not own, where it goes idle. Before restarting, software may load the current index back to the packet's first descriptor, which forces a full resend.

The output stream follows these back-pressure rules. A byte is offered with `tx_valid` high, and it is held unchanged until a cycle in which `tx_ready` is also high. `tx_valid` is never high while `cts` is low. `tx_valid` depends on the current cycle's `cts`, and `tx_data` is taken in the same cycle from `mem_data` for the address on `mem_addr`.

Top module: `txr_ring_tx`

## Requirements
- R1: After reset, `tx_valid` is 0, `stat_cur` is 0, `stat_aborted` is 0, every descriptor entry reads as all zeros and the engine is idle.
- R2: A descriptor word is laid out as {own, sop, eop, ptr[AW-1:0], len[LW-1:0]}, with own as the MSB (for defaults: own bit 26, sop bit 25, eop bit 24, ptr bits 23:8, len bits 7:0). A cycle with `sw_we` high writes `sw_wdata` into entry `sw_idx`, and `sw_rdata` shows entry `sw_idx` combinationally.
- R3: While idle, a cycle with `ctl_poll` high makes the engine check the current descriptor in the next cycle. If that descriptor is owned, sending starts in the cycle after the check. If it is not owned, the engine returns to idle and sends nothing.
- R4: A descriptor with length field L sends L+1 bytes, read from addresses ptr, ptr+1, …, ptr+L. `mem_addr` shows the address of the byte on offer, and `tx_data` equals `mem_data`.
- R5: A byte on offer with `tx_ready` low is held, with the same data and address, in the next cycle. `tx_valid` is low in every cycle where `cts` is low.
- R6: `tx_last` is high only with the final byte of a descriptor whose eop flag is set.
- R7: After the final byte of a descriptor is accepted, that descriptor's own bit reads 0. The current index then advances, wrapping from RING-1 to 0, and the next descriptor is checked in the following cycle.
- R8: If `cts` is low during a sending cycle, the engine halts and `stat_aborted` is 1 from the next cycle. The current descriptor keeps its own bit. `ctl_poll` alone or `ctl_start` alone leaves the engine halted.
- R9: In the halted state, a cycle with both `ctl_start` and `ctl_poll` high clears `stat_aborted`. If the current descriptor is owned and has sop set, its first byte is offered two cycles after the restart cycle.
- R10: After a restart, each owned descriptor without sop is released (own cleared) and the index advances, one descriptor per cycle. The walk stops at the first owned descriptor with sop set, where sending begins, or at the first unowned descriptor, where the engine goes idle.
- R11: A cycle with `cur_load` high, while the engine is idle or halted, sets the current index to `cur_val`. Rewinding to the packet's first descriptor before a restart makes the whole packet resend.
- R12: `stat_cur` always shows the current descriptor index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Descriptor write strobe |
| sw_idx | input | IW | Descriptor index for software read and write |
| sw_wdata | input | DW | Descriptor word to write |
| sw_rdata | output | DW | Descriptor word at sw_idx |
| ctl_start | input | 1 | Transmit-start control |
| ctl_poll | input | 1 | Poll control |
| cur_load | input | 1 | Load the current index (idle or halted only) |
| cur_val | input | IW | Index value to load |
| mem_addr | output | AW | Buffer byte address |
| mem_data | input | 8 | Buffer byte at mem_addr (same cycle) |
| cts | input | 1 | Clear-to-send from the line |
| tx_valid | output | 1 | Byte on offer |
| tx_ready | input | 1 | Framer accepts the byte |
| tx_data | output | 8 | Byte value |
| tx_last | output | 1 | Final byte of a packet |
| stat_cur | output | IW | Current descriptor index |
| stat_aborted | output | 1 | Transmission aborted, cleared by restart |

## Verification
The stream outputs and `sw_rdata` are combinational in the current state and inputs, so they are due in the same cycle as a change in `cts`, `tx_ready` or `sw_idx`. State effects land one cycle after the causing edge: the check follows a poll by one cycle, and the first byte follows it by two. `stat_aborted` follows loss of `cts` by one cycle, and a restart reaches its first byte two cycles later. The bench drives inputs just after each falling edge and compares every output, shortly after that, with a behavioural reference model. The model advances exactly once per rising edge, so each expected value is taken in the cycle where it is due. A few extra checks at fixed points confirm release, wrap, resend and rewind against hand-computed values.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SEND,
    ST_HALT,
    ST_SKIP
  } txr_state_e;
endpackage

// File: rtl/txr_desc_store.sv
module txr_desc_store #(
  parameter int RING = 8,
  parameter int IW   = 3,
  parameter int DW   = 27
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [IW-1:0] sw_idx,
  input  logic [DW-1:0] sw_wdata,
  output logic [DW-1:0] sw_rdata,
  input  logic [IW-1:0] cur_idx,
  input  logic          clr_en,
  output logic [DW-1:0] cur_desc
);
  logic [DW-1:0] ent [RING];

  for (genvar i = 0; i < RING; i++) begin : g_ent
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (sw_we && sw_idx == IW'(i)) begin
        q <= sw_wdata;
      end else if (clr_en && cur_idx == IW'(i)) begin
        q[DW-1] <= 1'b0;
      end
    end
    assign ent[i] = q;
  end

  assign sw_rdata = ent[sw_idx];
  assign cur_desc = ent[cur_idx];

  AST_RELEASE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> cur_desc[DW-1]); // R7
endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
#(
  parameter int RING = 8,
  parameter int IW   = 3,
  parameter int AW   = 16,
  parameter int LW   = 8,
  parameter int DW   = 3 + AW + LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cts,
  input  logic          tx_ready,
  input  logic          ctl_start,
  input  logic          ctl_poll,
  input  logic          cur_load,
  input  logic [IW-1:0] cur_val,
  input  logic [DW-1:0] cur_desc,
  output logic [IW-1:0] cur_idx,
  output logic          clr_en,
  output logic          tx_valid,
  output logic          tx_last,
  output logic [AW-1:0] byte_addr,
  output logic          aborted
);
  txr_state_e    st_q, st_d;
  logic [IW-1:0] cur_q, cur_d, cur_nxt;
  logic [LW-1:0] off_q, off_d;
  logic          ab_q, ab_d;

  logic          d_own, d_sop, d_eop, at_end, restart;
  logic [AW-1:0] d_ptr;
  logic [LW-1:0] d_len;

  assign d_own   = cur_desc[DW-1];
  assign d_sop   = cur_desc[DW-2];
  assign d_eop   = cur_desc[DW-3];
  assign d_ptr   = cur_desc[LW +: AW];
  assign d_len   = cur_desc[LW-1:0];
  assign at_end  = (off_q == d_len);
  assign restart = ctl_start && ctl_poll;
  assign cur_nxt = (cur_q == IW'(RING - 1)) ? '0 : cur_q + 1'b1;

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    off_d  = off_q;
    ab_d   = ab_q;
    clr_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cur_load) cur_d = cur_val;
        if (ctl_poll) st_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (d_own) begin
          st_d  = ST_SEND;
          off_d = '0;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_SEND: begin
        if (!cts) begin
          st_d = ST_HALT;
          ab_d = 1'b1;
        end else if (tx_ready) begin
          if (at_end) begin
            clr_en = 1'b1;
            cur_d  = cur_nxt;
            st_d   = ST_CHECK;
          end else begin
            off_d = off_q + 1'b1;
          end
        end
      end
      ST_HALT: begin
        if (cur_load) cur_d = cur_val;
        if (restart) begin
          ab_d = 1'b0;
          st_d = ST_SKIP;
        end
      end
      ST_SKIP: begin
        if (!d_own) begin
          st_d = ST_IDLE;
        end else if (d_sop) begin
          st_d  = ST_SEND;
          off_d = '0;
        end else begin
          clr_en = 1'b1;
          cur_d  = cur_nxt;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
      off_q <= '0;
      ab_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      off_q <= off_d;
      ab_q  <= ab_d;
    end
  end

  assign cur_idx   = cur_q;
  assign aborted   = ab_q;
  assign tx_valid  = (st_q == ST_SEND) && cts;
  assign tx_last   = tx_valid && d_eop && at_end;
  assign byte_addr = d_ptr + AW'(off_q);

  AST_ABORT_ON_CTS_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEND && !cts) |=> (aborted && st_q == ST_HALT)); // R8
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT && !restart) |=> (st_q == ST_HALT)); // R8
  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> ($stable(off_q) && $stable(cur_q))); // R5
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT && restart) |=> (!aborted && st_q == ST_SKIP)); // R9
endmodule

// File: rtl/txr_ring_tx.sv
module txr_ring_tx #(
  parameter int RING = 8,
  parameter int AW   = 16,
  parameter int LW   = 8,
  localparam int IW  = (RING > 1) ? $clog2(RING) : 1,
  localparam int DW  = 3 + AW + LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [IW-1:0] sw_idx,
  input  logic [DW-1:0] sw_wdata,
  output logic [DW-1:0] sw_rdata,
  input  logic          ctl_start,
  input  logic          ctl_poll,
  input  logic          cur_load,
  input  logic [IW-1:0] cur_val,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_data,
  input  logic          cts,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic [IW-1:0] stat_cur,
  output logic          stat_aborted
);
  logic [IW-1:0] cur_idx;
  logic          clr_en;
  logic [DW-1:0] cur_desc;

  txr_desc_store #(.RING(RING), .IW(IW), .DW(DW)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (sw_we),
    .sw_idx   (sw_idx),
    .sw_wdata (sw_wdata),
    .sw_rdata (sw_rdata),
    .cur_idx  (cur_idx),
    .clr_en   (clr_en),
    .cur_desc (cur_desc)
  );

  txr_ctrl #(.RING(RING), .IW(IW), .AW(AW), .LW(LW), .DW(DW)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cts       (cts),
    .tx_ready  (tx_ready),
    .ctl_start (ctl_start),
    .ctl_poll  (ctl_poll),
    .cur_load  (cur_load),
    .cur_val   (cur_val),
    .cur_desc  (cur_desc),
    .cur_idx   (cur_idx),
    .clr_en    (clr_en),
    .tx_valid  (tx_valid),
    .tx_last   (tx_last),
    .byte_addr (mem_addr),
    .aborted   (stat_aborted)
  );

  assign tx_data  = mem_data;
  assign stat_cur = cur_idx;
endmodule

// File: tb/txr_ring_tx_tb_top.sv
`timescale 1ns/1ps
module txr_ring_tx_tb_top;
  localparam int RING = 8;
  localparam int AW = 16;
  localparam int LW = 8;
  localparam int IW = 3;
  localparam int DW = 3 + AW + LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_we = 1'b0;
  logic [IW-1:0] sw_idx = '0;
  logic [DW-1:0] sw_wdata = '0;
  logic [DW-1:0] sw_rdata;
  logic ctl_start = 1'b0, ctl_poll = 1'b0, cur_load = 1'b0;
  logic [IW-1:0] cur_val = '0;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data;
  logic cts = 1'b1, tx_ready = 1'b1;
  logic tx_valid, tx_last;
  logic [7:0] tx_data;
  logic [IW-1:0] stat_cur;
  logic stat_aborted;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int lfsr = 32'h1d2c;
  bit rnd_ready = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign mem_data = pat(mem_addr);

  txr_ring_tx #(.RING(RING), .AW(AW), .LW(LW)) dut_i (.*);

  // behavioural reference model
  int m_own[RING], m_sop[RING], m_eop[RING], m_ptr[RING], m_len[RING];
  int m_st = 0;  // 0 idle, 1 check, 2 send, 3 halted, 4 skip
  int m_cur = 0, m_off = 0, m_ab = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  function automatic longint m_word(int i);
    return {m_own[i][0], m_sop[i][0], m_eop[i][0], m_ptr[i][15:0], m_len[i][7:0]};
  endfunction

  task automatic compare();
    int v;
    v = (m_st == 2 && cts) ? 1 : 0;
    chk("R5", "tx_valid", tx_valid, v);
    if (v != 0) begin
      chk("R4", "mem_addr", mem_addr, (m_ptr[m_cur] + m_off) & 16'hffff);
      chk("R4", "tx_data", tx_data, pat(16'((m_ptr[m_cur] + m_off) & 16'hffff)));
      chk("R6", "tx_last", tx_last, (m_eop[m_cur] != 0 && m_off == m_len[m_cur]) ? 1 : 0);
    end else begin
      chk("R6", "tx_last idle", tx_last, 0);
    end
    chk("R12", "stat_cur", stat_cur, m_cur);
    chk("R8", "stat_aborted", stat_aborted, m_ab);
    chk("R2", "sw_rdata", sw_rdata, m_word(int'(sw_idx)));
  endtask

  task automatic model_step();
    case (m_st)
      0: begin
        if (cur_load) m_cur = int'(cur_val);
        if (ctl_poll) m_st = 1;
      end
      1: begin
        if (m_own[m_cur] != 0) begin m_st = 2; m_off = 0; end
        else m_st = 0;
      end
      2: begin
        if (!cts) begin m_st = 3; m_ab = 1; end
        else if (tx_ready) begin
          if (m_off == m_len[m_cur]) begin
            m_own[m_cur] = 0;
            m_cur = (m_cur + 1) % RING;
            m_st = 1;
          end else m_off++;
        end
      end
      3: begin
        if (cur_load) m_cur = int'(cur_val);
        if (ctl_start && ctl_poll) begin m_ab = 0; m_st = 4; end
      end
      default: begin
        if (m_own[m_cur] == 0) m_st = 0;
        else if (m_sop[m_cur] != 0) begin m_st = 2; m_off = 0; end
        else begin
          m_own[m_cur] = 0;
          m_cur = (m_cur + 1) % RING;
        end
      end
    endcase
    if (sw_we) begin
      int i;
      i = int'(sw_idx);
      m_own[i] = sw_wdata[DW-1];
      m_sop[i] = sw_wdata[DW-2];
      m_eop[i] = sw_wdata[DW-3];
      m_ptr[i] = sw_wdata[LW +: AW];
      m_len[i] = sw_wdata[LW-1:0];
    end
  endtask

  task automatic tick();
    if (rnd_ready) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
      tx_ready = lfsr[0] | lfsr[3];
    end
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic wr(int i, bit o, bit s, bit e, int p, int l);
    sw_we = 1'b1;
    sw_idx = IW'(i);
    sw_wdata = {o, s, e, p[15:0], l[7:0]};
    tick();
    sw_we = 1'b0;
  endtask

  task automatic pulse(bit st, bit pl);
    ctl_start = st;
    ctl_poll = pl;
    tick();
    ctl_start = 1'b0;
    ctl_poll = 1'b0;
  endtask

  task automatic load(int v);
    cur_load = 1'b1;
    cur_val = IW'(v);
    tick();
    cur_load = 1'b0;
  endtask

  task automatic peek(int i);
    sw_idx = IW'(i);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < RING; i++) begin
      m_own[i] = 0; m_sop[i] = 0; m_eop[i] = 0; m_ptr[i] = 0; m_len[i] = 0;
    end
    @(negedge clk);
    @(negedge clk);
    #1;
    chk("R1", "reset tx_valid", tx_valid, 0);
    chk("R1", "reset stat_cur", stat_cur, 0);
    chk("R1", "reset stat_aborted", stat_aborted, 0);
    chk("R1", "reset entry 0", sw_rdata, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // two-descriptor packet under random back-pressure
    wr(0, 1, 1, 0, 'h0100, 2);
    wr(1, 1, 0, 1, 'h0200, 1);
    pulse(0, 1);
    tick();
    #1 chk("R3", "first byte two cycles after poll", tx_valid, 1);
    rnd_ready = 1'b1;
    run(30);
    rnd_ready = 1'b0;
    tx_ready = 1'b1;
    peek(0);
    chk("R7", "desc 0 released", sw_rdata[DW-1], 0);
    chk("R7", "index after packet", stat_cur, 2);

    // poll on an unowned descriptor
    pulse(0, 1);
    run(3);
    #1 chk("R3", "unowned poll sends nothing", tx_valid, 0);

    // ring wrap
    load(6);
    wr(6, 1, 1, 1, 'h0600, 0);
    wr(7, 1, 1, 1, 'h0700, 3);
    wr(0, 1, 1, 1, 'h0080, 1);
    pulse(0, 1);
    run(20);
    #1 chk("R7", "index wrapped to 1", stat_cur, 1);

    // abort in the first descriptor, restart resends
    wr(1, 1, 1, 0, 'h1000, 3);
    wr(2, 1, 0, 1, 'h1100, 2);
    pulse(0, 1);
    run(4);
    cts = 1'b0;
    run(3);
    #1 chk("R8", "aborted flag", stat_aborted, 1);
    chk("R5", "no byte without cts", tx_valid, 0);
    pulse(0, 1);
    pulse(1, 0);
    run(2);
    #1 chk("R8", "single control ignored", stat_aborted, 1);
    peek(1);
    chk("R8", "own kept on abort", sw_rdata[DW-1], 1);
    cts = 1'b1;
    pulse(1, 1);
    #1 chk("R9", "aborted cleared", stat_aborted, 0);
    tick();
    #1 chk("R9", "resend from ptr", mem_addr, 'h1000);
    chk("R9", "resend valid", tx_valid, 1);
    run(20);

    // abort in a middle descriptor, restart skips forward
    wr(3, 1, 1, 0, 'h2000, 1);
    wr(4, 1, 0, 1, 'h2100, 4);
    wr(5, 1, 1, 1, 'h2200, 1);
    pulse(0, 1);
    run(6);
    cts = 1'b0;
    run(2);
    cts = 1'b1;
    pulse(1, 1);
    run(2);
    #1 chk("R10", "send at next packet start", mem_addr, 'h2200);
    peek(4);
    chk("R10", "middle desc released", sw_rdata[DW-1], 0);
    run(20);
    #1 chk("R10", "idle at unowned entry", stat_cur, 6);

    // rewind before restart
    wr(6, 1, 1, 0, 'h3000, 0);
    wr(7, 1, 0, 1, 'h3100, 3);
    wr(0, 0, 0, 0, 0, 0);
    pulse(0, 1);
    run(4);
    cts = 1'b0;
    run(2);
    wr(6, 1, 1, 0, 'h3000, 0);
    load(6);
    #1 chk("R11", "index loaded while halted", stat_cur, 6);
    cts = 1'b1;
    pulse(1, 1);
    tick();
    #1 chk("R11", "full resend after rewind", mem_addr, 'h3000);
    chk("R11", "resend valid", tx_valid, 1);
    rnd_ready = 1'b1;
    run(30);
    rnd_ready = 1'b0;
    tx_ready = 1'b1;

    // skip stops at an unowned descriptor
    wr(1, 1, 1, 0, 'h4000, 0);
    wr(2, 1, 0, 1, 'h4100, 2);
    wr(3, 0, 1, 1, 'h4200, 0);
    load(1);
    pulse(0, 1);
    run(4);
    cts = 1'b0;
    run(2);
    cts = 1'b1;
    pulse(1, 1);
    run(4);
    #1 chk("R10", "skip ends at unowned", stat_cur, 3);
    chk("R10", "no send after skip", tx_valid, 0);
    run(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule